// File: doc/BRIEF.md
# SCL Divider Timing Generator

This block takes a requested clock divider ratio and turns it into a compact timing setting for a two-wire serial clock. The setting has three parts: a power-of-two prescaler exponent, a low-phase count and a high-phase count. The ratio is brought below 16 by repeated halving, one halving per clock. If any bit that is shifted out is set, the result is rounded up. The normalised value is then split into two phase counts that may differ by one.

The computed setting is shown on the configuration outputs, together with a timeout code chosen from the requested bus speed. The setting is then held pending. It is handed to a phase generator only at the start of an SCL low phase. The phase generator drives the SCL level and marks the last cycle of every phase. A load request with a requested speed of zero is refused.

Top module: `scl_timing_gen`

## Requirements
- R1: An accepted ratio is halved once per clock while it is 16 or more. The exponent on `cfg_exp` equals the number of halvings.
- R2: If any bit removed by the halvings was 1, the normalised value is the remaining ratio plus one. Otherwise it is the remaining ratio. A remaining value below 2 is raised to 2.
- R3: For normalised value n, `cfg_low` = floor(n/2) - 1 and `cfg_high` = n - `cfg_low` - 2.
- R4: `cfg_timeout` is 3 when the requested speed is strictly greater than `HS_THRESH`. Otherwise it is 0, which means no timeout. It updates together with the other results.
- R5: A load with `cfg_speed` equal to 0 is refused. No `cfg_done` pulse follows and no configuration output changes.
- R6: `cfg_done` is a one-cycle pulse. It rises k+2 clock edges after the accepting edge, where k is the number of halvings.
- R7: A load that arrives while a normalisation is running is ignored. Only the running request produces a result.
- R8: Each low phase lasts (low+1)·2^exp clocks and each high phase lasts (high+1)·2^exp clocks.
- R9: SCL stays high after reset until the first result is committed. After that, a new result takes effect only at the start of a low phase, so the current phase finishes with the old counts.
- R10: `phase_adv_o` is high for exactly one clock per phase: the last clock of that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Strobe that requests a new timing computation |
| cfg_ratio | input | RATIO_W | Requested divider ratio |
| cfg_speed | input | SPEED_W | Requested bus speed; 0 refuses the load |
| cfg_done | output | 1 | Pulse when new results are presented |
| cfg_exp | output | 4 | Prescaler exponent of the latest result |
| cfg_low | output | 4 | Low-phase count of the latest result |
| cfg_high | output | 4 | High-phase count of the latest result |
| cfg_timeout | output | TMO_W | Timeout code: 3 in high-speed mode, 0 otherwise |
| scl_o | output | 1 | SCL level |
| phase_adv_o | output | 1 | Marks the last clock of the current SCL phase |

## Verification
The bench checks every ratio from 0 to 255 and a set of large ratios. This covers the point where 16 becomes one halving, the round-up that turns 31 into 16, and the raise of ratios 0 and 1 to 2. A design with wrong round-up or a wrong shift count gives phase counts that are off by one or a wrong exponent. The speed threshold is checked at both of its neighbouring values, where a comparison that is wrong by one picks the wrong timeout. SCL phase widths are measured while a new setting arrives in the middle of a high phase. A design that commits early shortens that high phase. Loads with zero speed and loads that arrive while busy are also sent, and a design that does not refuse them shows an extra `cfg_done` pulse or changed outputs.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;
  localparam int EXP_W     = 4;
  localparam int PH_W      = 4;
  localparam int NORM_LIM  = 16;
  localparam int NORM_W    = $clog2(NORM_LIM) + 1;
  localparam int PRE_W     = (1 << EXP_W) - 1;

  typedef struct packed {
    logic [EXP_W-1:0] exp;
    logic [PH_W-1:0]  low;
    logic [PH_W-1:0]  high;
  } timing_t;

  // Raise values below 2 so the phase split cannot underflow.
  function automatic logic [NORM_W-1:0] clamp_norm(input logic [NORM_W-1:0] n);
    return (n < NORM_W'(2)) ? NORM_W'(2) : n;
  endfunction

  function automatic logic [PH_W-1:0] low_of(input logic [NORM_W-1:0] n);
    return PH_W'((n >> 1) - NORM_W'(1));
  endfunction

  function automatic logic [PH_W-1:0] high_of(input logic [NORM_W-1:0] n);
    return PH_W'(n - {1'b0, low_of(n)} - NORM_W'(2));
  endfunction
endpackage

// File: rtl/scl_ratio_norm.sv
module scl_ratio_norm
  import scl_tg_pkg::*;
#(
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [EXP_W-1:0]   exp_o,
  output logic [NORM_W-1:0]  norm_o
);
  typedef enum logic {N_IDLE, N_SHIFT} nstate_t;

  nstate_t            st_q;
  logic [RATIO_W-1:0] work_q;
  logic [EXP_W-1:0]   exp_q;
  logic               sticky_q;
  logic               done_q;
  logic [NORM_W-1:0]  norm_q;
  logic               need_shift;

  assign need_shift = (work_q >= RATIO_W'(NORM_LIM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= N_IDLE;
      work_q   <= '0;
      exp_q    <= '0;
      sticky_q <= 1'b0;
      done_q   <= 1'b0;
      norm_q   <= NORM_W'(2);
    end else begin
      done_q <= 1'b0;
      case (st_q)
        N_IDLE: begin
          if (start_i) begin
            work_q   <= ratio_i;
            exp_q    <= '0;
            sticky_q <= 1'b0;
            st_q     <= N_SHIFT;
          end
        end
        default: begin
          if (need_shift) begin
            work_q   <= work_q >> 1;
            sticky_q <= sticky_q | work_q[0];
            exp_q    <= exp_q + 1'b1;
          end else begin
            norm_q <= clamp_norm({1'b0, work_q[3:0]} + NORM_W'(sticky_q));
            done_q <= 1'b1;
            st_q   <= N_IDLE;
          end
        end
      endcase
    end
  end

  assign busy_o = (st_q == N_SHIFT);
  assign done_o = done_q;
  assign exp_o  = exp_q;
  assign norm_o = norm_q;

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == N_SHIFT && need_shift) |=> (exp_q == $past(exp_q) + 1'b1)); // R1
  AST_NORM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (norm_q >= NORM_W'(2) && norm_q <= NORM_W'(NORM_LIM))); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R6
endmodule

// File: rtl/scl_base_tick.sv
module scl_base_tick
  import scl_tg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;

  assign limit  = (PRE_W'(1) << exp_i) - PRE_W'(1);
  assign tick_o = (pre_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pre_q <= '0;
    else if (restart_i || tick_o) pre_q <= '0;
    else                        pre_q <= pre_q + 1'b1;
  end

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (pre_q == '0)); // R8
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
  import scl_tg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pend_valid_i,
  input  timing_t pend_i,
  output logic    commit_o,
  output logic    scl_o,
  output logic    phase_adv_o
);
  logic            running_q;
  logic            scl_q;
  timing_t         act_q;
  logic [PH_W-1:0] ph_q;
  logic            base_tick;
  logic            phase_end;
  logic            commit;

  scl_base_tick u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart_i(commit),
    .exp_i    (act_q.exp),
    .tick_o   (base_tick)
  );

  assign phase_end = running_q && base_tick &&
                     (ph_q == (scl_q ? act_q.high : act_q.low));
  assign commit    = pend_valid_i && (!running_q || (phase_end && scl_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      scl_q     <= 1'b1;
      act_q     <= '0;
      ph_q      <= '0;
    end else if (commit) begin
      running_q <= 1'b1;
      scl_q     <= 1'b0;
      act_q     <= pend_i;
      ph_q      <= '0;
    end else if (phase_end) begin
      scl_q <= ~scl_q;
      ph_q  <= '0;
    end else if (running_q && base_tick) begin
      ph_q <= ph_q + 1'b1;
    end
  end

  assign commit_o    = commit;
  assign scl_o       = scl_q;
  assign phase_adv_o = phase_end;

  AST_SCL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_end && !commit) |=> $stable(scl_q)); // R8
  AST_COMMIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (!scl_q && running_q)); // R9
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !running_q |-> scl_q); // R9
  AST_ADV_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    phase_end |=> (scl_q != $past(scl_q))); // R10
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_tg_pkg::*;
#(
  parameter int RATIO_W    = 16,
  parameter int SPEED_W    = 24,
  parameter int HS_THRESH  = 400000,
  parameter int TMO_W      = 4,
  parameter int HS_TIMEOUT = 3,
  parameter int NO_TIMEOUT = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_load,
  input  logic [RATIO_W-1:0] cfg_ratio,
  input  logic [SPEED_W-1:0] cfg_speed,
  output logic               cfg_done,
  output logic [EXP_W-1:0]   cfg_exp,
  output logic [PH_W-1:0]    cfg_low,
  output logic [PH_W-1:0]    cfg_high,
  output logic [TMO_W-1:0]   cfg_timeout,
  output logic               scl_o,
  output logic               phase_adv_o
);
  logic              accept;
  logic              speed_zero;
  logic              norm_busy;
  logic              norm_done;
  logic [EXP_W-1:0]  norm_exp;
  logic [NORM_W-1:0] norm_val;
  logic              hs_job_q;
  logic              done_q;
  timing_t           res_q;
  logic [TMO_W-1:0]  tmo_q;
  logic              pend_valid_q;
  logic              commit;

  assign speed_zero = (cfg_speed == '0);
  assign accept     = cfg_load && !speed_zero && !norm_busy;

  scl_ratio_norm #(.RATIO_W(RATIO_W)) u_norm (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(accept),
    .ratio_i(cfg_ratio),
    .busy_o (norm_busy),
    .done_o (norm_done),
    .exp_o  (norm_exp),
    .norm_o (norm_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_job_q     <= 1'b0;
      done_q       <= 1'b0;
      res_q        <= '0;
      tmo_q        <= TMO_W'(NO_TIMEOUT);
      pend_valid_q <= 1'b0;
    end else begin
      done_q <= norm_done;
      if (accept) hs_job_q <= (cfg_speed > SPEED_W'(HS_THRESH));
      if (norm_done) begin
        res_q.exp  <= norm_exp;
        res_q.low  <= low_of(norm_val);
        res_q.high <= high_of(norm_val);
        tmo_q      <= hs_job_q ? TMO_W'(HS_TIMEOUT) : TMO_W'(NO_TIMEOUT);
        pend_valid_q <= 1'b1;
      end else if (commit) begin
        pend_valid_q <= 1'b0;
      end
    end
  end

  scl_phase_gen u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .pend_valid_i(pend_valid_q),
    .pend_i      (res_q),
    .commit_o    (commit),
    .scl_o       (scl_o),
    .phase_adv_o (phase_adv_o)
  );

  assign cfg_done    = done_q;
  assign cfg_exp     = res_q.exp;
  assign cfg_low     = res_q.low;
  assign cfg_high    = res_q.high;
  assign cfg_timeout = tmo_q;

  AST_ZERO_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && speed_zero && !norm_busy) |=> !norm_busy); // R5
  AST_TMO_HS: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_done && hs_job_q) |=> (tmo_q == TMO_W'(HS_TIMEOUT))); // R4
  AST_SPLIT_BAL: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (res_q.low <= res_q.high && res_q.high <= res_q.low + 1'b1)); // R3
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_busy && !norm_done) |=> !done_q); // R7
endmodule

// File: tb/scl_timing_gen_bench.sv
module scl_timing_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [15:0] cfg_ratio = '0;
  logic [23:0] cfg_speed = '0;
  logic        cfg_done;
  logic [3:0]  cfg_exp, cfg_low, cfg_high, cfg_timeout;
  logic        scl_o, phase_adv_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  scl_timing_gen u_scl_timing_gen (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_ratio(cfg_ratio),
    .cfg_speed(cfg_speed), .cfg_done(cfg_done), .cfg_exp(cfg_exp),
    .cfg_low(cfg_low), .cfg_high(cfg_high), .cfg_timeout(cfg_timeout),
    .scl_o(scl_o), .phase_adv_o(phase_adv_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Halving count: position of the top set bit above bit 3.
  function automatic int k_of(input int r);
    int k = 0;
    for (int b = 4; b < 16; b++) if (((r >> b) & 1) == 1) k = b - 3;
    return k;
  endfunction
  function automatic int n_of(input int r);
    int k = k_of(r);
    int raw = (r >> k) + (((r % (1 << k)) != 0) ? 1 : 0);
    return (raw < 2) ? 2 : raw;
  endfunction
  function automatic int lo_of(input int n); return n / 2 - 1; endfunction
  function automatic int hi_of(input int n); return n - lo_of(n) - 2; endfunction

  task automatic do_load(input int r, input int spd, output int lat);
    @(negedge clk);
    cfg_load = 1'b1; cfg_ratio = 16'(r); cfg_speed = 24'(spd);
    @(negedge clk);
    cfg_load = 1'b0;
    lat = 0;
    while (lat < 100) begin
      @(negedge clk);
      lat++;
      if (cfg_done) break;
    end
  endtask

  task automatic load_check(input int r, input int spd);
    int lat;
    int n = n_of(r);
    do_load(r, spd, lat);
    chk("R6 latency", lat, k_of(r) + 2);
    chk("R1 exponent", cfg_exp, k_of(r));
    chk("R2/R3 low", cfg_low, lo_of(n));
    chk("R2/R3 high", cfg_high, hi_of(n));
    chk("R4 timeout", cfg_timeout, (spd > 400000) ? 3 : 0);
    @(negedge clk);
    chk("R6 single pulse", cfg_done, 0);
  endtask

  task automatic measure(output int lo, output int hi, output int lo_adv,
                         output int hi_adv, output int lo_last, output int hi_last);
    int g = 0;
    bit prev = scl_o;
    @(negedge clk);
    while (!(prev == 1'b1 && scl_o == 1'b0) && g < 20000) begin
      prev = scl_o; @(negedge clk); g++;
    end
    lo = 0; lo_adv = 0; lo_last = 0;
    while (scl_o == 1'b0 && lo < 20000) begin
      lo++; lo_adv += int'(phase_adv_o); lo_last = int'(phase_adv_o); @(negedge clk);
    end
    hi = 0; hi_adv = 0; hi_last = 0;
    while (scl_o == 1'b1 && hi < 20000) begin
      hi++; hi_adv += int'(phase_adv_o); hi_last = int'(phase_adv_o); @(negedge clk);
    end
  endtask

  task automatic timing_check(input int r);
    int lo, hi, la, ha, ll, hl;
    int n = n_of(r);
    int m = 1 << k_of(r);
    int lat;
    do_load(r, 100000, lat);
    measure(lo, hi, la, ha, ll, hl);
    measure(lo, hi, la, ha, ll, hl);
    chk("R8 low width", lo, (lo_of(n) + 1) * m);
    chk("R8 high width", hi, (hi_of(n) + 1) * m);
    chk("R10 low adv count", la, 1);
    chk("R10 low adv last", ll, 1);
    chk("R10 high adv count", ha, 1);
    chk("R10 high adv last", hl, 1);
  endtask

  initial begin
    int hi, lo, g, dones;
    bit prev;
    int sv_exp, sv_low, sv_high, sv_tmo;
    int big[8] = '{1000, 4095, 4096, 4097, 30000, 32768, 40000, 65534};

    repeat (3) @(negedge clk);
    chk("R9 reset scl", scl_o, 1);
    chk("R6 reset done", cfg_done, 0);
    chk("R1 reset exp", cfg_exp, 0);
    chk("R4 reset timeout", cfg_timeout, 0);
    chk("R10 reset adv", phase_adv_o, 0);
    rst_n = 1'b1;
    g = 0;
    repeat (10) begin @(negedge clk); g += int'(scl_o); end
    chk("R9 idle high before first result", g, 10);

    timing_check(100);
    timing_check(24);

    // R9: new setting loaded at start of a high phase waits for the next low.
    prev = scl_o; g = 0;
    @(negedge clk);
    while (!(prev == 1'b0 && scl_o == 1'b1) && g < 5000) begin
      prev = scl_o; @(negedge clk); g++;
    end
    cfg_load = 1'b1; cfg_ratio = 16'd40; cfg_speed = 24'd100000;
    hi = 1;
    @(negedge clk);
    cfg_load = 1'b0;
    while (scl_o == 1'b1 && hi < 5000) begin hi++; @(negedge clk); end
    lo = 0;
    while (scl_o == 1'b0 && lo < 5000) begin lo++; @(negedge clk); end
    chk("R9 old high kept", hi, 12);
    chk("R9 new low applied", lo, 20);

    timing_check(1);

    for (int r = 0; r < 256; r++) load_check(r, (r % 2 == 1) ? 400001 : 400000);
    foreach (big[i]) load_check(big[i], 1000000);

    // R5: zero speed refused.
    sv_exp = cfg_exp; sv_low = cfg_low; sv_high = cfg_high; sv_tmo = cfg_timeout;
    @(negedge clk);
    cfg_load = 1'b1; cfg_ratio = 16'd200; cfg_speed = '0;
    @(negedge clk);
    cfg_load = 1'b0;
    dones = 0;
    repeat (20) begin @(negedge clk); dones += int'(cfg_done); end
    chk("R5 no done", dones, 0);
    chk("R5 exp unchanged", cfg_exp, sv_exp);
    chk("R5 low unchanged", cfg_low, sv_low);
    chk("R5 high unchanged", cfg_high, sv_high);
    chk("R5 timeout unchanged", cfg_timeout, sv_tmo);

    // R7: load during busy ignored.
    @(negedge clk);
    cfg_load = 1'b1; cfg_ratio = 16'd65535; cfg_speed = 24'd1000000;
    @(negedge clk);
    cfg_load = 1'b0;
    @(negedge clk);
    cfg_load = 1'b1; cfg_ratio = 16'd5; cfg_speed = 24'd100000;
    @(negedge clk);
    cfg_load = 1'b0;
    dones = 0;
    repeat (30) begin @(negedge clk); dones += int'(cfg_done); end
    chk("R7 one result", dones, 1);
    chk("R7 exp of first", cfg_exp, 12);
    chk("R7 low of first", cfg_low, 7);
    chk("R7 high of first", cfg_high, 7);
    chk("R7 timeout of first", cfg_timeout, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule